// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter sits at the head of a receive path. It watches the first six bytes of each incoming frame, which make up the 48-bit destination address, and issues one accept or reject verdict per frame together with a code naming the rule that decided it. Bytes arrive one per clock with a valid strobe. A start marker travels with the first byte, and an end marker closes the frame.

There are four acceptance rules and one override. The first compares the destination against a single programmed station address. The second and third look the destination up in one of two 64-bin hash tables: one table serves individual addresses and the other serves group addresses. The bin number is taken from an Ethernet CRC-32 that is accumulated byte by byte while the address arrives. The fourth rule is a single control bit that either admits or refuses all-ones broadcast frames. A promiscuous control admits every complete address. All configuration is latched when a frame starts, so writes made during a frame take effect on the next one.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A destination whose first byte has bit 0 clear is accepted with reason code 1 (exact) when it equals `station_addr_i`. Wire byte k is compared with bits [8k+7:8k].
- R2: A destination with bit 0 clear that fails the exact compare is accepted with reason 2 (unicast hash) when bit `bin` of `ind_hash_i` is set. `bin` is bits [31:26] of a CRC register that starts at all ones and shifts in the six bytes LSB first with polynomial 0x04C11DB7. There is no final inversion.
- R3: A destination with bit 0 of its first byte set, other than all ones, is accepted with reason 3 (multicast hash) only when bit `bin` of `grp_hash_i` is set. `ind_hash_i` never admits a group destination, and `grp_hash_i` never admits an individual one.
- R4: An all-ones destination is accepted with reason 4 when `bcast_reject_i` is 0. It is rejected with reason 0 when that bit is 1, whatever `grp_hash_i` holds.
- R5: With `promisc_i` set, every frame that delivers six address bytes is accepted with reason 5. This rule takes priority over all other rules.
- R6: A frame matched by no rule is rejected with reason 0. Whenever `dec_valid_o` is high, `dec_accept_o` is 1 exactly when the reason is nonzero.
- R7: `dec_valid_o` goes high for exactly one cycle, in the cycle after the sixth address byte is consumed. It stays low while the address bytes arrive, and bytes after the sixth do not raise it.
- R8: When `eof_i` arrives in a frame before six bytes have been consumed, a reject with reason 0 is issued in the next cycle, even in promiscuous mode.
- R9: `sof_i` with a valid byte restarts the byte count and the CRC, even in the middle of a frame. The interrupted frame produces no verdict.
- R10: All configuration inputs are sampled with the first byte of a frame. Changes made later in that frame do not affect its verdict.
- R11: While `rst_ni` is low, and after it is released, `dec_valid_o`, `dec_accept_o` and `dec_reason_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | `byte_i` carries a frame byte |
| sof_i | input | 1 | First byte of a frame, qualified by `byte_valid_i` |
| eof_i | input | 1 | Frame has ended |
| byte_i | input | 8 | Received byte |
| station_addr_i | input | 48 | Station address; wire byte k in bits [8k+7:8k] |
| ind_hash_i | input | 64 | Individual-address hash bins |
| grp_hash_i | input | 64 | Group-address hash bins |
| bcast_reject_i | input | 1 | 1 refuses broadcast frames |
| promisc_i | input | 1 | Accept every complete address |
| dec_valid_o | output | 1 | Verdict strobe |
| dec_accept_o | output | 1 | 1 = accept |
| dec_reason_o | output | 3 | 0 none, 1 exact, 2 unicast hash, 3 multicast hash, 4 broadcast, 5 promiscuous |

## Verification
A stale CRC or byte counter shows up at the first verdict after the fault. A counter that is off moves the strobe by a cycle. A CRC that was not restarted selects the wrong bin, which turns a hash hit into a reject. The restart test therefore sets exactly one bin, computed for the clean address. Miss tests set every bin except the correct one, so any index error turns into a visible accept. Mid-frame configuration writes and trailing bytes expose latching faults or a missing clear of the frame-active state within the same frame.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;
  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_EXACT   = 3'd1,
    RSN_UHASH   = 3'd2,
    RSN_MHASH   = 3'd3,
    RSN_BCAST   = 3'd4,
    RSN_PROMISC = 3'd5
  } reason_e;

  localparam logic [31:0] ETH_CRC_POLY = 32'h04C11DB7;
endpackage

// File: rtl/eth_af_crc.sv
module eth_af_crc #(
  parameter logic [31:0] POLY = eth_af_pkg::ETH_CRC_POLY
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_nxt_o
);
  logic [31:0] crc_q;
  logic [31:0] c;
  logic        fb;

  // LSB-first serial update, unrolled over one byte
  always_comb begin
    c  = clear_i ? '1 : crc_q;
    fb = 1'b0;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ byte_i[i];
      c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    crc_nxt_o = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '1;
    else if (en_i) crc_q <= c;
  end
endmodule

// File: rtl/eth_af_decide.sv
module eth_af_decide
  import eth_af_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6,
  localparam int BINS     = 1 << HASH_BITS
) (
  input  logic [ADDR_W-1:0]    da_i,
  input  logic [HASH_BITS-1:0] bin_i,
  input  logic [ADDR_W-1:0]    station_i,
  input  logic [BINS-1:0]      ind_hash_i,
  input  logic [BINS-1:0]      grp_hash_i,
  input  logic                 bcast_rej_i,
  input  logic                 promisc_i,
  output logic                 accept_o,
  output reason_e              reason_o
);
  logic is_grp, is_bcast;

  assign is_grp   = da_i[0];
  assign is_bcast = &da_i;

  // priority: promiscuous, broadcast, group hash, exact, individual hash
  always_comb begin
    accept_o = 1'b0;
    reason_o = RSN_NONE;
    if (promisc_i) begin
      accept_o = 1'b1;
      reason_o = RSN_PROMISC;
    end else if (is_bcast) begin
      accept_o = !bcast_rej_i;
      reason_o = bcast_rej_i ? RSN_NONE : RSN_BCAST;
    end else if (is_grp) begin
      if (grp_hash_i[bin_i]) begin
        accept_o = 1'b1;
        reason_o = RSN_MHASH;
      end
    end else if (da_i == station_i) begin
      accept_o = 1'b1;
      reason_o = RSN_EXACT;
    end else if (ind_hash_i[bin_i]) begin
      accept_o = 1'b1;
      reason_o = RSN_UHASH;
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int BINS      = 1 << HASH_BITS,
  localparam int CNT_W     = $clog2(ADDR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [BINS-1:0]   ind_hash_i,
  input  logic [BINS-1:0]   grp_hash_i,
  input  logic              bcast_reject_i,
  input  logic              promisc_i,
  output logic              dec_valid_o,
  output logic              dec_accept_o,
  output logic [2:0]        dec_reason_o
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q, cur_cnt;
  logic [ADDR_W-1:0] da_q, da_nxt;
  logic [ADDR_W-1:0] station_q, station_eff;
  logic [BINS-1:0]   ind_q, ind_eff, grp_q, grp_eff;
  logic              bcrej_q, bcrej_eff, prom_q, prom_eff;
  logic              start, take, last, short_frame;
  logic [31:0]       crc_nxt;
  logic              acc;
  reason_e           rsn;

  assign start       = sof_i & byte_valid_i;
  assign take        = byte_valid_i & (start | active_q);
  assign cur_cnt     = start ? '0 : cnt_q;
  assign last        = take & (cur_cnt == CNT_W'(ADDR_BYTES - 1));
  assign short_frame = eof_i & (active_q | start) & ~last;

  // config in effect: live on the first byte, latched afterwards
  assign station_eff = start ? station_addr_i : station_q;
  assign ind_eff     = start ? ind_hash_i     : ind_q;
  assign grp_eff     = start ? grp_hash_i     : grp_q;
  assign bcrej_eff   = start ? bcast_reject_i : bcrej_q;
  assign prom_eff    = start ? promisc_i      : prom_q;

  always_comb begin
    da_nxt = start ? '0 : da_q;
    if (take) da_nxt[{cur_cnt, 3'b000} +: 8] = byte_i;
  end

  eth_af_crc u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .en_i      (take),
    .byte_i    (byte_i),
    .crc_nxt_o (crc_nxt)
  );

  eth_af_decide #(
    .ADDR_W    (ADDR_W),
    .HASH_BITS (HASH_BITS)
  ) u_decide (
    .da_i        (da_nxt),
    .bin_i       (crc_nxt[31 -: HASH_BITS]),
    .station_i   (station_eff),
    .ind_hash_i  (ind_eff),
    .grp_hash_i  (grp_eff),
    .bcast_rej_i (bcrej_eff),
    .promisc_i   (prom_eff),
    .accept_o    (acc),
    .reason_o    (rsn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      cnt_q        <= '0;
      da_q         <= '0;
      station_q    <= '0;
      ind_q        <= '0;
      grp_q        <= '0;
      bcrej_q      <= 1'b0;
      prom_q       <= 1'b0;
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_reason_o <= RSN_NONE;
    end else begin
      if (last || short_frame) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (take) begin
        active_q <= 1'b1;
        cnt_q    <= cur_cnt + 1'b1;
      end
      if (take) da_q <= da_nxt;
      if (start) begin
        station_q <= station_addr_i;
        ind_q     <= ind_hash_i;
        grp_q     <= grp_hash_i;
        bcrej_q   <= bcast_reject_i;
        prom_q    <= promisc_i;
      end
      dec_valid_o  <= last | short_frame;
      dec_accept_o <= last & acc;
      dec_reason_o <= last ? rsn : RSN_NONE;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(ADDR_BYTES));

  // R5
  promisc_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && prom_eff) |=> (dec_accept_o && dec_reason_o == RSN_PROMISC));

  // R8
  short_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_frame |=> (dec_valid_o && !dec_accept_o && dec_reason_o == RSN_NONE));

  // R6
  accept_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_accept_o == (dec_reason_o != RSN_NONE)));

  // R1
  exact_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !prom_eff && !da_nxt[0] && da_nxt == station_eff)
      |=> (dec_accept_o && dec_reason_o == RSN_EXACT));
endmodule

// File: tb/tb_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_eth_rx_addr_filter;
  localparam logic [2:0] R_NONE = 3'd0, R_EXACT = 3'd1, R_UHASH = 3'd2,
                         R_MHASH = 3'd3, R_BCAST = 3'd4, R_PROM = 3'd5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [47:0] station_addr_i = '0;
  logic [63:0] ind_hash_i = '0, grp_hash_i = '0;
  logic        bcast_reject_i = 1'b0, promisc_i = 1'b0;
  logic        dec_valid_o, dec_accept_o;
  logic [2:0]  dec_reason_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eth_rx_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .sof_i(sof_i),
    .eof_i(eof_i), .byte_i(byte_i), .station_addr_i(station_addr_i),
    .ind_hash_i(ind_hash_i), .grp_hash_i(grp_hash_i),
    .bcast_reject_i(bcast_reject_i), .promisc_i(promisc_i),
    .dec_valid_o(dec_valid_o), .dec_accept_o(dec_accept_o),
    .dec_reason_o(dec_reason_o)
  );

  localparam logic [47:0] ADDR_A  = 48'h55_44_33_22_11_02;
  localparam logic [47:0] ADDR_B  = 48'h0a_09_08_07_06_04;
  localparam logic [47:0] ADDR_M  = 48'h01_00_5e_00_00_01;
  localparam logic [47:0] ADDR_BC = '1;

  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic msb = r[31];
      r = r << 1;
      if (msb != a[k]) r = r ^ 32'h04C1_1DB7;
    end
    return r[31:26];
  endfunction

  function automatic logic [63:0] one_bin(input logic [5:0] b);
    return 64'd1 << b;
  endfunction

  task automatic step(input logic v, input logic s, input logic e, input logic [7:0] b);
    byte_valid_i = v; sof_i = s; eof_i = e; byte_i = b;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {valid,accept,reason} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic v, input logic a, input logic [2:0] r);
    chk(req, {dec_valid_o, dec_accept_o, dec_reason_o}, {v, a, r});
  endtask

  // full six-byte address, verdict check, quiet before and after
  task automatic frame_check(input string req, input logic [47:0] a,
                             input logic acc, input logic [2:0] rsn);
    int early = 0;
    for (int k = 0; k < 6; k++) begin
      step(1'b1, k == 0, 1'b0, a[8*k +: 8]);
      if (k < 5 && dec_valid_o) early++;
    end
    chk_out(req, 1'b1, acc, rsn);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    chk_out({req, " R7 single cycle"}, 1'b0, 1'b0, R_NONE);
    chk({req, " R7 quiet before"}, 5'(early), 5'd0);
  endtask

  task automatic t_reset;
    chk_out("R11 in reset", 1'b0, 1'b0, R_NONE);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_out("R11 after reset", 1'b0, 1'b0, R_NONE);
  endtask

  task automatic t_exact;
    station_addr_i = ADDR_A; ind_hash_i = '0; grp_hash_i = '0;
    frame_check("R1 exact", ADDR_A, 1'b1, R_EXACT);
  endtask

  task automatic t_uhash;
    station_addr_i = ADDR_A;
    ind_hash_i = one_bin(bin_of(ADDR_B)); grp_hash_i = '0;
    frame_check("R2 unicast hash hit", ADDR_B, 1'b1, R_UHASH);
    ind_hash_i = ~one_bin(bin_of(ADDR_B));
    frame_check("R6 unicast hash miss", ADDR_B, 1'b0, R_NONE);
    ind_hash_i = '0; grp_hash_i = '1;
    frame_check("R3 group table ignores unicast", ADDR_B, 1'b0, R_NONE);
  endtask

  task automatic t_mhash;
    ind_hash_i = '0; grp_hash_i = one_bin(bin_of(ADDR_M));
    frame_check("R3 multicast hash hit", ADDR_M, 1'b1, R_MHASH);
    grp_hash_i = ~one_bin(bin_of(ADDR_M));
    frame_check("R3 multicast hash miss", ADDR_M, 1'b0, R_NONE);
    ind_hash_i = '1; grp_hash_i = '0; station_addr_i = ADDR_M;
    frame_check("R3 individual table ignores group", ADDR_M, 1'b0, R_NONE);
    ind_hash_i = '0; station_addr_i = ADDR_A;
  endtask

  task automatic t_bcast;
    grp_hash_i = '0; bcast_reject_i = 1'b0;
    frame_check("R4 broadcast accepted", ADDR_BC, 1'b1, R_BCAST);
    grp_hash_i = '1; bcast_reject_i = 1'b1;
    frame_check("R4 broadcast refused", ADDR_BC, 1'b0, R_NONE);
    grp_hash_i = '0;
  endtask

  task automatic t_promisc;
    promisc_i = 1'b1;
    frame_check("R5 promiscuous unicast", ADDR_B, 1'b1, R_PROM);
    frame_check("R5 promiscuous over broadcast refuse", ADDR_BC, 1'b1, R_PROM);
    frame_check("R5 promiscuous over exact", ADDR_A, 1'b1, R_PROM);
    promisc_i = 1'b0; bcast_reject_i = 1'b0;
  endtask

  task automatic t_short;
    promisc_i = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b1, k == 0, 1'b0, ADDR_A[8*k +: 8]);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    chk_out("R8 short frame reject", 1'b1, 1'b0, R_NONE);
    step(1'b1, 1'b1, 1'b1, 8'h02);
    chk_out("R8 one-byte frame reject", 1'b1, 1'b0, R_NONE);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    chk_out("R8 single strobe", 1'b0, 1'b0, R_NONE);
    promisc_i = 1'b0;
  endtask

  task automatic t_restart;
    station_addr_i = ADDR_A; ind_hash_i = one_bin(bin_of(ADDR_B));
    for (int k = 0; k < 3; k++) step(1'b1, k == 0, 1'b0, ADDR_M[8*k +: 8]);
    frame_check("R9 restart clears count and crc", ADDR_B, 1'b1, R_UHASH);
    ind_hash_i = '0;
  endtask

  task automatic t_cfg_sample;
    station_addr_i = ADDR_A; promisc_i = 1'b0;
    for (int k = 0; k < 2; k++) step(1'b1, k == 0, 1'b0, ADDR_A[8*k +: 8]);
    station_addr_i = ADDR_B; promisc_i = 1'b1;
    for (int k = 2; k < 6; k++) step(1'b1, 1'b0, 1'b0, ADDR_A[8*k +: 8]);
    chk_out("R10 mid-frame write ignored (exact kept)", 1'b1, 1'b1, R_EXACT);
    promisc_i = 1'b0;
    step(1'b1, 1'b1, 1'b0, ADDR_A[7:0]);
    station_addr_i = ADDR_A; ind_hash_i = '1;
    for (int k = 1; k < 6; k++) step(1'b1, 1'b0, 1'b0, ADDR_A[8*k +: 8]);
    chk_out("R10 mid-frame write ignored (reject kept)", 1'b1, 1'b0, R_NONE);
    ind_hash_i = '0;
    step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_trailing;
    int extra = 0;
    station_addr_i = ADDR_A;
    frame_check("R7 exact before trailing", ADDR_A, 1'b1, R_EXACT);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 1'b0, 8'hA0 + 8'(k));
      if (dec_valid_o) extra++;
    end
    step(1'b0, 1'b0, 1'b1, 8'h00);
    if (dec_valid_o) extra++;
    step(1'b0, 1'b0, 1'b0, 8'h00);
    if (dec_valid_o) extra++;
    chk("R7 trailing bytes give no verdict", 5'(extra), 5'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_uhash();
    t_mhash();
    t_bcast();
    t_promisc();
    t_short();
    t_restart();
    t_cfg_sample();
    t_trailing();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule